// File: doc/BRIEF.md
# Descriptor-Driven Single-Channel DMA Mover

This block moves a programmed number of data items from a source address to a destination address. Software gives it three values: a 32-bit control word, a source address and a destination address. A pulse on `start` hands them over. The control word sets the item count, the item width (8, 16 or 32 bits) and, for each address, whether it advances by the item size after every item or stays on one location.

Each item is one read handshake on the source side followed by one write handshake on the destination side. Byte enables mark the lanes that hold the item. The data is shifted from the source lane position to the destination lane position. While the block runs, it shows how many items are still to move.

A descriptor that cannot be carried out produces a one-cycle error pulse, and nothing starts. Such a descriptor has a reserved width, a misaligned address, a count that is too large, or a fixed address in a memory-to-memory move. A sticky completion flag reports the end of a run unless the descriptor suppresses it.

Top module: `dma_desc_engine`

## Requirements
- R1: Control word fields: count in bits [31:16], width code in [13:12], destination step code in [11:10], source step code in [9:8], flag suppress in bit [7]. Accepting a valid descriptor makes `busy` high and `items_left` equal to count+1 on the next cycle.
- R2: `items_left` drops by one in the cycle after each accepted write. It reaches 0 after the last item. `busy` falls in the cycle after the last write is accepted.
- R3: Width code 00 is a byte, 01 a half-word, 10 a word. Byte enables are 4'b0001 shifted left by addr[1:0] for a byte, 4'b0011 or 4'b1100 (selected by addr[1]) for a half-word, and 4'b1111 for a word, on both the read and the write side.
- R4: A step code of 11 keeps that address fixed. Any other code adds 1, 2 or 4 (the item size) to that address after each item.
- R5: Each item is one read followed by one write. The write is not offered before the read is accepted, and the next read is not offered before the write is accepted. A valid request keeps its address, enables and data until it is accepted.
- R6: The item is the read data shifted right by 8*src[1:0] and masked to the item width. `wr_data` is that item shifted left by 8*dst[1:0], with all other bits zero.
- R7: A start with any of the following gives a one-cycle `err` pulse in the next cycle, leaves `busy` low and issues no access: width code 11, a source or destination address not aligned to the item size, a count field above 16383, or `mem_to_mem` high with either step code equal to 11.
- R8: After the last write is accepted, `done_flag` rises in the next cycle unless bit [7] was set. It stays high until a `done_clr` pulse clears it.
- R9: `start` is ignored while `busy` is high: no `err` pulse and no change of `items_left`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Accept the descriptor inputs (one-cycle pulse) |
| desc_ctl | input | 32 | Descriptor control word |
| desc_src | input | 32 | Source start address |
| desc_dst | input | 32 | Destination start address |
| mem_to_mem | input | 1 | Transfer type is memory to memory |
| done_clr | input | 1 | Write-one-to-clear of the completion flag |
| busy | output | 1 | Transfer in progress |
| err | output | 1 | One-cycle descriptor rejection pulse |
| items_left | output | 15 | Items still to move |
| done_flag | output | 1 | Sticky completion flag |
| rd_valid | output | 1 | Read request valid |
| rd_addr | output | 32 | Read address |
| rd_be | output | 4 | Read byte enables |
| rd_ready | input | 1 | Read accepted, data valid on rd_data |
| rd_data | input | 32 | Read data |
| wr_valid | output | 1 | Write request valid |
| wr_addr | output | 32 | Write address |
| wr_be | output | 4 | Write byte enables |
| wr_data | output | 32 | Write data |
| wr_ready | input | 1 | Write accepted |

## Verification
The timing the bench relies on is as follows:
- A start is answered one cycle later, either by `busy` with `items_left` loaded or by the `err` pulse.
- A read request is visible in the cycle the transfer starts.
- A write request follows one cycle after the read is accepted.
- The next read, the decremented count and, on the last item, the falling `busy` and the rising flag all follow one cycle after the write is accepted.

The bench drives inputs at the falling edge and compares outputs at the next falling edge, which is exactly one rising edge later. Random ready stalls check that the requests hold steady for as many cycles as the stall lasts.

// File: rtl/dma_desc_pkg.sv
package dma_desc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RD   = 2'd1,
        ST_WR   = 2'd2
    } xfer_st_e;

    localparam logic [1:0] WID_BYTE  = 2'b00;
    localparam logic [1:0] WID_HALF  = 2'b01;
    localparam logic [1:0] WID_WORD  = 2'b10;
    localparam logic [1:0] WID_RSVD  = 2'b11;
    localparam logic [1:0] STEP_HOLD = 2'b11;

    typedef struct packed {
        logic [15:0] count;
        logic [1:0]  rsv_hi;
        logic [1:0]  width;
        logic [1:0]  dst_step;
        logic [1:0]  src_step;
        logic        no_flag;
        logic [6:0]  rsv_lo;
    } ctl_word_t;

    function automatic int unsigned item_bytes(input logic [1:0] w);
        case (w)
            WID_HALF: item_bytes = 2;
            WID_WORD: item_bytes = 4;
            default:  item_bytes = 1;
        endcase
    endfunction

endpackage

// File: rtl/dma_desc_check.sv
module dma_desc_check
    import dma_desc_pkg::*;
#(
    parameter int MAX_ITEMS = 16384,
    parameter int CNT_W     = 16,
    parameter int LB        = 2
) (
    input  logic [CNT_W-1:0] count,
    input  logic [1:0]       width,
    input  logic [1:0]       src_step,
    input  logic [1:0]       dst_step,
    input  logic [LB-1:0]    src_lo,
    input  logic [LB-1:0]    dst_lo,
    input  logic             mem_to_mem,
    output logic             ok
);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(MAX_ITEMS - 1);

    logic bad_width, bad_align, bad_count, bad_hold;

    function automatic logic misaligned(input logic [LB-1:0] lo, input logic [1:0] w);
        case (w)
            WID_HALF: misaligned = lo[0];
            WID_WORD: misaligned = |lo;
            default:  misaligned = 1'b0;
        endcase
    endfunction

    always_comb begin
        bad_width = (width == WID_RSVD);
        bad_align = misaligned(src_lo, width) | misaligned(dst_lo, width);
        bad_count = (count > CNT_MAX);
        bad_hold  = mem_to_mem & ((src_step == STEP_HOLD) | (dst_step == STEP_HOLD));
        ok        = !(bad_width | bad_align | bad_count | bad_hold);
    end
endmodule

// File: rtl/dma_port_calc.sv
module dma_port_calc
    import dma_desc_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int LANES  = 4,
    parameter int LB     = $clog2(LANES)
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [1:0]        width,
    input  logic [1:0]        step,
    output logic [LANES-1:0]  be,
    output logic [ADDR_W-1:0] addr_nx
);
    always_comb begin
        case (width)
            WID_HALF: be = LANES'(3) << {addr[LB-1:1], 1'b0};
            WID_WORD: be = '1;
            default:  be = LANES'(1) << addr[LB-1:0];
        endcase
        if (step == STEP_HOLD) addr_nx = addr;
        else                   addr_nx = addr + ADDR_W'(item_bytes(width));
    end
endmodule

// File: rtl/dma_desc_engine.sv
module dma_desc_engine
    import dma_desc_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int DATA_W    = 32,
    parameter int MAX_ITEMS = 16384,
    parameter int CNT_W     = 16,
    parameter int LANES     = DATA_W / 8,
    parameter int LEFT_W    = $clog2(MAX_ITEMS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [31:0]       desc_ctl,
    input  logic [ADDR_W-1:0] desc_src,
    input  logic [ADDR_W-1:0] desc_dst,
    input  logic              mem_to_mem,
    input  logic              done_clr,
    output logic              busy,
    output logic              err,
    output logic [LEFT_W-1:0] items_left,
    output logic              done_flag,
    output logic              rd_valid,
    output logic [ADDR_W-1:0] rd_addr,
    output logic [LANES-1:0]  rd_be,
    input  logic              rd_ready,
    input  logic [DATA_W-1:0] rd_data,
    output logic              wr_valid,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [LANES-1:0]  wr_be,
    output logic [DATA_W-1:0] wr_data,
    input  logic              wr_ready
);
    localparam int LB = $clog2(LANES);

    typedef struct packed {
        xfer_st_e          st;
        logic [ADDR_W-1:0] sa;
        logic [ADDR_W-1:0] da;
        logic [1:0]        width;
        logic [1:0]        sstep;
        logic [1:0]        dstep;
        logic              no_flag;
        logic [LEFT_W-1:0] left;
        logic [DATA_W-1:0] item;
        logic              err;
        logic              done;
    } eng_t;

    eng_t d, q;
    ctl_word_t cw;
    logic desc_ok;

    logic [ADDR_W-1:0] pa   [2];
    logic [1:0]        pstp [2];
    logic [LANES-1:0]  pbe  [2];
    logic [ADDR_W-1:0] pnx  [2];

    assign cw = ctl_word_t'(desc_ctl);

    dma_desc_check #(.MAX_ITEMS(MAX_ITEMS), .CNT_W(CNT_W), .LB(LB)) u_check (
        .count(cw.count), .width(cw.width), .src_step(cw.src_step), .dst_step(cw.dst_step),
        .src_lo(desc_src[LB-1:0]), .dst_lo(desc_dst[LB-1:0]),
        .mem_to_mem(mem_to_mem), .ok(desc_ok)
    );

    assign pa[0]   = q.sa;
    assign pa[1]   = q.da;
    assign pstp[0] = q.sstep;
    assign pstp[1] = q.dstep;

    for (genvar gi = 0; gi < 2; gi++) begin : g_port
        dma_port_calc #(.ADDR_W(ADDR_W), .LANES(LANES), .LB(LB)) u_calc (
            .addr(pa[gi]), .width(q.width), .step(pstp[gi]),
            .be(pbe[gi]), .addr_nx(pnx[gi])
        );
    end

    function automatic logic [DATA_W-1:0] width_mask(input logic [1:0] w);
        case (w)
            WID_BYTE: width_mask = DATA_W'(8'hFF);
            WID_HALF: width_mask = DATA_W'(16'hFFFF);
            default:  width_mask = '1;
        endcase
    endfunction

    always_comb begin
        d     = q;
        d.err = 1'b0;
        if (done_clr) d.done = 1'b0;
        case (q.st)
            ST_IDLE: begin
                if (start) begin
                    if (desc_ok) begin
                        d.st      = ST_RD;
                        d.sa      = desc_src;
                        d.da      = desc_dst;
                        d.width   = cw.width;
                        d.sstep   = cw.src_step;
                        d.dstep   = cw.dst_step;
                        d.no_flag = cw.no_flag;
                        d.left    = LEFT_W'(cw.count) + LEFT_W'(1);
                    end else begin
                        d.err = 1'b1;
                    end
                end
            end
            ST_RD: begin
                if (rd_ready) begin
                    d.item = (rd_data >> {q.sa[LB-1:0], 3'b000}) & width_mask(q.width);
                    d.st   = ST_WR;
                end
            end
            ST_WR: begin
                if (wr_ready) begin
                    d.left = q.left - LEFT_W'(1);
                    d.sa   = pnx[0];
                    d.da   = pnx[1];
                    if (q.left == LEFT_W'(1)) begin
                        d.st = ST_IDLE;
                        if (!q.no_flag) d.done = 1'b1;
                    end else begin
                        d.st = ST_RD;
                    end
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: ST_IDLE, width: WID_BYTE, default: '0};
        end else begin
            q <= d;
        end
    end

    assign busy       = (q.st != ST_IDLE);
    assign err        = q.err;
    assign items_left = q.left;
    assign done_flag  = q.done;
    assign rd_valid   = (q.st == ST_RD);
    assign rd_addr    = q.sa;
    assign rd_be      = pbe[0];
    assign wr_valid   = (q.st == ST_WR);
    assign wr_addr    = q.da;
    assign wr_be      = pbe[1];
    assign wr_data    = q.item << {q.da[LB-1:0], 3'b000};

    assert_err_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (!busy && !rd_valid && !wr_valid));

    assert_rd_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_addr) && $stable(rd_be)));

    assert_wr_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr) && $stable(wr_data) && $stable(wr_be)));

    assert_one_phase_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_valid && wr_valid));

    assert_left_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && wr_ready) |=> (items_left == $past(items_left) - LEFT_W'(1)));

    assert_be_count_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> ($countones(rd_be) == item_bytes(q.width)));

    assert_hold_addr_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && wr_ready && q.sstep == STEP_HOLD) |=> (q.sa == $past(q.sa)));

    assert_flag_src_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_flag) |-> $past(wr_valid && wr_ready));

    assert_idle_empty_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (items_left == '0));
endmodule

// File: tb/dma_desc_engine_tb.sv
module dma_desc_engine_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] desc_ctl = '0, desc_src = '0, desc_dst = '0;
    logic        mem_to_mem = 1'b0, done_clr = 1'b0;
    logic        busy, err, done_flag, rd_valid, wr_valid;
    logic [14:0] items_left;
    logic [31:0] rd_addr, wr_addr, wr_data;
    logic [3:0]  rd_be, wr_be;
    logic        rd_ready = 1'b0, wr_ready = 1'b0;
    logic [31:0] rd_data = '0;

    int vecs = 0;
    int bad  = 0;
    int cyc  = 0;
    int unsigned seed_dummy;

    always #10 clk = ~clk;

    dma_desc_engine dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .desc_ctl(desc_ctl),
        .desc_src(desc_src), .desc_dst(desc_dst), .mem_to_mem(mem_to_mem),
        .done_clr(done_clr), .busy(busy), .err(err), .items_left(items_left),
        .done_flag(done_flag), .rd_valid(rd_valid), .rd_addr(rd_addr), .rd_be(rd_be),
        .rd_ready(rd_ready), .rd_data(rd_data), .wr_valid(wr_valid), .wr_addr(wr_addr),
        .wr_be(wr_be), .wr_data(wr_data), .wr_ready(wr_ready)
    );

    task automatic summary_and_end();
        $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc == 190000) begin
            bad++;
            $display("FAIL watchdog: act=%0d cycles exp<190000", cyc);
            summary_and_end();
        end
    end

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        vecs++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: act=%h exp=%h", req, what, act, exp);
        end
    endtask

    function automatic int unsigned sz(input logic [1:0] w);
        return (w == 2'b01) ? 2 : (w == 2'b10) ? 4 : 1;
    endfunction

    function automatic logic [3:0] exp_be(input logic [1:0] w, input logic [31:0] a);
        if (w == 2'b00) return 4'b0001 << a[1:0];
        if (w == 2'b01) return a[1] ? 4'b1100 : 4'b0011;
        return 4'b1111;
    endfunction

    function automatic logic [31:0] exp_wdata(input logic [1:0] w, input logic [31:0] s,
                                              input logic [31:0] dd, input logic [31:0] raw);
        logic [31:0] m, it;
        m  = (w == 2'b00) ? 32'hFF : (w == 2'b01) ? 32'hFFFF : 32'hFFFF_FFFF;
        it = (raw >> (8 * s[1:0])) & m;
        return it << (8 * dd[1:0]);
    endfunction

    function automatic logic [31:0] mk_ctl(input int cnt, input logic [1:0] w, input logic [1:0] ds,
                                           input logic [1:0] ss, input logic nf);
        return {cnt[15:0], 2'b00, w, ds, ss, nf, 7'b0};
    endfunction

    task automatic run_desc(input logic [31:0] ctl, input logic [31:0] s, input logic [31:0] dd,
                            input logic m2m, input bit exp_err, input bit stalls, input bit poke);
        int n;
        logic [1:0] w;
        logic [31:0] sa, da, raw;
        n = int'(ctl[31:16]) + 1;
        w = ctl[13:12];
        sa = s; da = dd;
        desc_ctl = ctl; desc_src = s; desc_dst = dd; mem_to_mem = m2m; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (exp_err) begin
            chk("R7", "err pulse", 32'(err), 1);
            chk("R7", "busy low", 32'(busy), 0);
            chk("R7", "no read", 32'(rd_valid), 0);
            @(negedge clk);
            chk("R7", "err one cycle", 32'(err), 0);
            chk("R7", "still idle", 32'(busy), 0);
            return;
        end
        chk("R1", "busy", 32'(busy), 1);
        chk("R1", "items_left load", 32'(items_left), 32'(n));
        for (int i = 0; i < n; i++) begin
            chk("R5", "rd_valid", 32'(rd_valid), 1);
            chk("R5", "no early write", 32'(wr_valid), 0);
            chk("R4", "rd_addr", rd_addr, sa);
            chk("R3", "rd_be", 32'(rd_be), 32'(exp_be(w, sa)));
            if (poke && i == 0) begin
                desc_ctl = mk_ctl(0, 2'b11, 2'b00, 2'b00, 1'b0); start = 1'b1;
                @(negedge clk);
                start = 1'b0;
                chk("R9", "no err while busy", 32'(err), 0);
                chk("R9", "items_left kept", 32'(items_left), 32'(n));
            end
            if (stalls) begin
                int k;
                k = int'($urandom_range(0, 2));
                for (int j = 0; j < k; j++) begin
                    @(negedge clk);
                    chk("R5", "rd held", rd_addr, sa);
                end
            end
            raw = $urandom;
            rd_data = raw; rd_ready = 1'b1;
            @(negedge clk);
            rd_ready = 1'b0; rd_data = $urandom;
            chk("R5", "wr_valid", 32'(wr_valid), 1);
            chk("R5", "rd dropped", 32'(rd_valid), 0);
            chk("R4", "wr_addr", wr_addr, da);
            chk("R3", "wr_be", 32'(wr_be), 32'(exp_be(w, da)));
            chk("R6", "wr_data", wr_data, exp_wdata(w, sa, da, raw));
            if (stalls) begin
                int k;
                k = int'($urandom_range(0, 2));
                for (int j = 0; j < k; j++) begin
                    @(negedge clk);
                    chk("R5", "wr held", wr_data, exp_wdata(w, sa, da, raw));
                end
            end
            wr_ready = 1'b1;
            @(negedge clk);
            wr_ready = 1'b0;
            chk("R2", "items_left dec", 32'(items_left), 32'(n - i - 1));
            if (ctl[9:8] != 2'b11) sa = sa + sz(w);
            if (ctl[11:10] != 2'b11) da = da + sz(w);
        end
        chk("R2", "busy falls", 32'(busy), 0);
        chk("R8", "done flag", 32'(done_flag), 32'(!ctl[7]));
        @(negedge clk);
        chk("R8", "flag sticky", 32'(done_flag), 32'(!ctl[7]));
        done_clr = 1'b1;
        @(negedge clk);
        done_clr = 1'b0;
        chk("R8", "flag cleared", 32'(done_flag), 0);
    endtask

    initial begin
        seed_dummy = $urandom(32'h5EED_1234);
        repeat (3) @(negedge clk);
        chk("R1", "reset busy", 32'(busy), 0);
        chk("R2", "reset items_left", 32'(items_left), 0);
        chk("R8", "reset flag", 32'(done_flag), 0);
        chk("R7", "reset err", 32'(err), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // directed: single byte item, odd lanes, both stepping
        run_desc(mk_ctl(0, 2'b00, 2'b00, 2'b00, 1'b0), 32'h1000_0003, 32'h2000_0001, 1'b1, 0, 0, 0);
        // half-words, fixed destination, peripheral type, flag suppressed
        run_desc(mk_ctl(3, 2'b01, 2'b11, 2'b01, 1'b1), 32'h0000_0102, 32'h4000_0000, 1'b0, 0, 1, 0);
        // words, fixed source, with start poke while busy (R9)
        run_desc(mk_ctl(2, 2'b10, 2'b10, 2'b11, 1'b0), 32'h0000_0400, 32'h0000_0800, 1'b0, 0, 1, 1);
        // rejections (R7)
        run_desc(mk_ctl(1, 2'b11, 2'b00, 2'b00, 1'b0), 32'h0, 32'h0, 1'b0, 1, 0, 0);
        run_desc(mk_ctl(1, 2'b01, 2'b00, 2'b00, 1'b0), 32'h1, 32'h0, 1'b0, 1, 0, 0);
        run_desc(mk_ctl(1, 2'b10, 2'b00, 2'b00, 1'b0), 32'h0, 32'h2, 1'b0, 1, 0, 0);
        run_desc(mk_ctl(16384, 2'b00, 2'b00, 2'b00, 1'b0), 32'h0, 32'h0, 1'b0, 1, 0, 0);
        run_desc(mk_ctl(1, 2'b00, 2'b11, 2'b00, 1'b0), 32'h0, 32'h0, 1'b1, 1, 0, 0);
        run_desc(mk_ctl(1, 2'b00, 2'b00, 2'b11, 1'b0), 32'h0, 32'h0, 1'b1, 1, 0, 0);

        // random descriptors
        for (int r = 0; r < 40; r++) begin
            logic [1:0] w, ds, ss;
            logic [31:0] s, dd;
            logic m2m;
            int cnt;
            w   = 2'($urandom_range(0, 2));
            ds  = 2'($urandom_range(0, 3));
            ss  = 2'($urandom_range(0, 3));
            m2m = (ds != 2'b11 && ss != 2'b11) ? 1'($urandom_range(0, 1)) : 1'b0;
            cnt = int'($urandom_range(0, 5));
            s   = $urandom & ~(sz(w) - 1);
            dd  = $urandom & ~(sz(w) - 1);
            run_desc(mk_ctl(cnt, w, ds, ss, 1'($urandom_range(0, 1))), s, dd, m2m, 0, 1, 0);
        end

        // largest count: 16384 items
        run_desc(mk_ctl(16383, 2'b10, 2'b00, 2'b00, 1'b0), 32'h0001_0000, 32'h0002_0000, 1'b1, 0, 0, 0);

        summary_and_end();
    end
endmodule